// File: doc/BRIEF.md
# Multi-Register Stack Transfer Engine

This block carries out two stack instructions on a word-addressed push-down stack. A push-multiple copies a run of general registers onto the stack. A pull-multiple reloads a run of registers from the stack. A 64-bit stack descriptor describes the stack. It holds a 17-bit top-of-stack address, a 15-bit free-space count, a 15-bit occupied-word count and two trap-inhibit flags. The caller gives a start strobe, the operation, a first register number, a 4-bit transfer count and the descriptor. The block then checks both stack limits before it moves any word.

An operation that passes the checks moves one word per step. Each step connects the 16-entry register file to a word-wide memory port that uses a valid/ready handshake. Register numbers wrap from 15 back to 0. A stack address in the range 0..15 names a general register, so that transfer goes to the register file and the memory port is not used. A refused operation moves nothing and leaves the descriptor unchanged. It reports the reason in the condition code and raises a trap pulse unless the matching inhibit flag is set. At the end of every operation the block pulses `done_o` and presents the condition code and the resulting descriptor, which stay valid until the next operation ends.

Top module: `pds_engine`

## Requirements
- R1: A transfer count of 0 moves 16 words. Any other count n moves n words.
- R2: Register numbers wrap modulo 16, so register 0 follows register 15.
- R3: A push reads registers base, base+1, … in ascending order and writes them to stack addresses top+1, top+2, …, top+n (addresses modulo 2^17).
- R4: A pull loads register base+n-1 first, from address top. It continues downward and loads register base last, from address top-(n-1).
- R5: Descriptor layout (bit 0 = LSB): occupied words [14:0], word-inhibit flag [15], free space [30:16], space-inhibit flag [31], top address [48:32], bits [63:49] spare. On completion a push adds n to top and words and subtracts n from space. A pull does the opposite. Flags and spare bits are always returned unchanged.
- R6: A push is refused if free space < n (shortage) or if words + n > 32767 (overflow). In that case no register or memory location is written and the returned descriptor equals the input.
- R7: A pull is refused if words < n (shortage) or if space + n > 32767 (overflow), with the same no-write, unchanged-descriptor behaviour.
- R8: On a refused operation `trap_o` pulses with `done_o` when a shortage occurs with the space-inhibit flag at 0, or when an overflow occurs with the word-inhibit flag at 0. Otherwise `trap_o` stays 0.
- R9: Condition code `cc_o`: bit3 = refused, bit2 = overflow, bit1 = shortage, bit0 = zero. On completion bits 3..1 are 0 and bit0 is 1 when the new space (push) or new word count (pull) is 0. On refusal bit0 is 0.
- R10: A transfer whose stack address lies in 0..15 uses register (address) in the register file and never asserts `mem_valid_o`.
- R11: Each memory transfer is one accepted valid/ready beat. While ready is low, valid and the address hold steady.
- R12: After reset `busy_o`, `done_o`, `trap_o`, `mem_valid_o` and `rf_we_o` are 0 and `cc_o` and `sp_o` are 0. `done_o` is a single-cycle pulse per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| op_pull_i | input | 1 | 0 = push-multiple, 1 = pull-multiple |
| base_reg_i | input | 4 | First register number of the run |
| count_i | input | 4 | Transfer count, 0 meaning 16 |
| sp_i | input | 64 | Stack descriptor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| trap_o | output | 1 | Stack-limit trap pulse |
| cc_o | output | 4 | Condition code |
| sp_o | output | 64 | Resulting descriptor |
| rf_rd_addr_o | output | 4 | Register file read address |
| rf_rd_data_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_wr_addr_o | output | 4 | Register file write address |
| rf_wr_data_o | output | 32 | Register file write data |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory request accepted |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 17 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the accepting cycle |

## Verification
The bench aims at limits that are hit exactly and limits that are missed by one: space equal to n, words at 32767-n, and both faults together with only one of them inhibited. A design with an off-by-one compare would trap on a legal push, or it would move words into a full stack. Counts of 0 and runs that cross register 15 check for a 0-word transfer and for writes into the wrong register numbers. Stack ranges that cross between high memory and addresses 0..15 check whether those words go to registers rather than memory. A reversed pull order shows up as permuted register contents. Random ready stalls show whether a beat is lost or written twice.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;
  // Descriptor field positions (LSB = bit 0); neighbours decode these.
  localparam int SP_W     = 64;
  localparam int ADDR_W   = 17;
  localparam int CNT_W    = 15;
  localparam int WC_LSB   = 0;
  localparam int TW_BIT   = 15;
  localparam int SC_LSB   = 16;
  localparam int TS_BIT   = 31;
  localparam int TSA_LSB  = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_MOVE  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic refused;
    logic over;
    logic shortage;
    logic zero;
  } cc_t;
endpackage

// File: rtl/pds_limit.sv
`timescale 1ns/1ps
module pds_limit
  import pds_pkg::*;
#(
  parameter int NUM_W = 5
) (
  input  logic            op_pull,
  input  logic [NUM_W-1:0] num,
  input  logic [SP_W-1:0] sp,
  output logic            refuse,
  output logic            trap_req,
  output cc_t             cc_refuse,
  output cc_t             cc_finish,
  output logic [SP_W-1:0] sp_next
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [ADDR_W-1:0] top_a, top_n;
  logic [CNT_W-1:0]  space_c, words_c, space_n, words_n;
  logic [CNT_W-1:0]  num_c;
  logic [CNT_W:0]    num_x, avail_x, other_x;
  logic [ADDR_W-1:0] num_a;
  logic              inh_space, inh_words, short_f, over_f;

  assign top_a     = sp[TSA_LSB +: ADDR_W];
  assign space_c   = sp[SC_LSB +: CNT_W];
  assign words_c   = sp[WC_LSB +: CNT_W];
  assign inh_space = sp[TS_BIT];
  assign inh_words = sp[TW_BIT];

  assign num_x = {{(CNT_W+1-NUM_W){1'b0}}, num};
  assign num_c = num_x[CNT_W-1:0];
  assign num_a = {{(ADDR_W-NUM_W){1'b0}}, num};

  // the count that must cover n, and the count that must not overflow
  assign avail_x = {1'b0, (op_pull ? words_c : space_c)};
  assign other_x = {1'b0, (op_pull ? space_c : words_c)};

  assign short_f  = avail_x < num_x;
  assign over_f   = (other_x + num_x) > CNT_MAX;
  assign refuse   = short_f | over_f;
  assign trap_req = (short_f & ~inh_space) | (over_f & ~inh_words);

  always_comb begin
    cc_refuse          = '0;
    cc_refuse.refused  = 1'b1;
    cc_refuse.over     = over_f;
    cc_refuse.shortage = short_f;
  end

  always_comb begin
    if (op_pull) begin
      top_n   = top_a - num_a;
      space_n = space_c + num_c;
      words_n = words_c - num_c;
    end else begin
      top_n   = top_a + num_a;
      space_n = space_c - num_c;
      words_n = words_c + num_c;
    end
  end

  always_comb begin
    cc_finish      = '0;
    cc_finish.zero = op_pull ? (words_n == '0) : (space_n == '0);
  end

  always_comb begin
    sp_next                       = sp;
    sp_next[TSA_LSB +: ADDR_W]    = top_n;
    sp_next[SC_LSB +: CNT_W]      = space_n;
    sp_next[WC_LSB +: CNT_W]      = words_n;
  end
endmodule

// File: rtl/pds_route.sv
`timescale 1ns/1ps
module pds_route
  import pds_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  parameter int NUM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              op_pull,
  input  logic [REG_W-1:0]  base,
  input  logic [NUM_W-1:0]  num,
  input  logic [REG_W-1:0]  idx,
  input  logic [ADDR_W-1:0] top,
  input  logic [DATA_W-1:0] rf_rd_data,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [REG_W-1:0]  rf_rd_addr,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              step_done
);
  logic [REG_W-1:0]  reg_sel, last_off;
  logic [ADDR_W-1:0] stk_addr;
  logic              to_regs;

  assign last_off = REG_W'(num - 1'b1);
  assign reg_sel  = op_pull ? (base + last_off - idx) : (base + idx);
  assign stk_addr = op_pull ? (top - ADDR_W'(idx)) : (top + ADDR_W'(idx) + ADDR_W'(1));
  assign to_regs  = ~|stk_addr[ADDR_W-1:REG_W];

  assign mem_addr  = stk_addr;
  assign mem_wdata = rf_rd_data;
  assign mem_we    = ~op_pull;
  assign mem_valid = active & ~to_regs;
  assign step_done = active & (to_regs | mem_ready);

  always_comb begin
    rf_rd_addr = reg_sel;
    rf_wr_addr = reg_sel;
    rf_wr_data = rf_rd_data;
    rf_we      = 1'b0;
    if (op_pull) begin
      if (to_regs) begin
        rf_rd_addr = stk_addr[REG_W-1:0];
        rf_we      = active;
      end else begin
        rf_wr_data = mem_rdata;
        rf_we      = active & mem_ready;
      end
    end else begin
      rf_wr_addr = stk_addr[REG_W-1:0];
      rf_we      = active & to_regs;
    end
  end

  // R10
  mem_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr >= ADDR_W'(1 << REG_W)));

  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && mem_we && rf_we));
endmodule

// File: rtl/pds_seq.sv
`timescale 1ns/1ps
module pds_seq
  import pds_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_pull_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [REG_W-1:0] count_i,
  input  logic [SP_W-1:0]  sp_i,
  input  logic             refuse,
  input  logic             trap_req,
  input  cc_t              cc_refuse,
  input  cc_t              cc_finish,
  input  logic [SP_W-1:0]  sp_next,
  input  logic             step_done,
  output logic             busy,
  output logic             active,
  output logic             op_q,
  output logic [REG_W-1:0] base_q,
  output logic [NUM_W-1:0] num_q,
  output logic [REG_W-1:0] idx_q,
  output logic [SP_W-1:0]  sp_q,
  output logic             done_o,
  output logic             trap_o,
  output cc_t              cc_o,
  output logic [SP_W-1:0]  sp_o
);
  seq_state_e       state_q, state_d;
  logic [REG_W-1:0] idx_d;
  logic [NUM_W-1:0] num_d;
  logic             lat_en, idx_en, res_en, last_step;
  logic             done_d, trap_d;
  cc_t              cc_d;
  logic [SP_W-1:0]  spo_d;

  assign num_d     = (count_i == '0) ? NUM_W'(1 << REG_W) : NUM_W'(count_i);
  assign last_step = (idx_q == REG_W'(num_q - 1'b1));
  assign busy      = (state_q != ST_IDLE);
  assign active    = (state_q == ST_MOVE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    lat_en  = 1'b0;
    idx_en  = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    cc_d    = cc_o;
    spo_d   = sp_o;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          lat_en  = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (refuse) begin
          state_d = ST_IDLE;
          res_en  = 1'b1;
          done_d  = 1'b1;
          trap_d  = trap_req;
          cc_d    = cc_refuse;
          spo_d   = sp_q;
        end else begin
          state_d = ST_MOVE;
          idx_en  = 1'b1;
          idx_d   = '0;
        end
      end
      ST_MOVE: begin
        if (step_done) begin
          if (last_step) begin
            state_d = ST_IDLE;
            res_en  = 1'b1;
            done_d  = 1'b1;
            cc_d    = cc_finish;
            spo_d   = sp_next;
          end else begin
            idx_en = 1'b1;
            idx_d  = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      trap_o  <= 1'b0;
      op_q    <= 1'b0;
      base_q  <= '0;
      num_q   <= '0;
      sp_q    <= '0;
      idx_q   <= '0;
      cc_o    <= '0;
      sp_o    <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      trap_o  <= trap_d;
      if (lat_en) begin
        op_q   <= op_pull_i;
        base_q <= base_i;
        num_q  <= num_d;
        sp_q   <= sp_i;
      end
      if (idx_en) idx_q <= idx_d;
      if (res_en) begin
        cc_o <= cc_d;
        sp_o <= spo_d;
      end
    end
  end

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  trap_only_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (done_o && cc_o.refused));

  // R6 R7
  refused_keeps_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cc_o.refused) |-> (sp_o == sp_q));

  // R5
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cc_o.refused) |->
      ((16'(sp_o[SC_LSB +: CNT_W]) + 16'(sp_o[WC_LSB +: CNT_W])) ==
       (16'(sp_q[SC_LSB +: CNT_W]) + 16'(sp_q[WC_LSB +: CNT_W]))));

  // R1
  finish_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cc_o.refused) |-> $past(step_done));
endmodule

// File: rtl/pds_engine.sv
`timescale 1ns/1ps
module pds_engine
  import pds_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 16,
  parameter int REG_W  = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_pull_i,
  input  logic [REG_W-1:0]  base_reg_i,
  input  logic [REG_W-1:0]  count_i,
  input  logic [63:0]       sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [3:0]        cc_o,
  output logic [63:0]       sp_o,
  output logic [REG_W-1:0]  rf_rd_addr_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_wr_addr_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [16:0]       mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int NUM_W = REG_W + 1;

  logic             rst_meta, rst_sync;
  logic             refuse, trap_req, step_done, active, op_q;
  cc_t              cc_refuse, cc_finish, cc_q;
  logic [SP_W-1:0]  sp_next, sp_q;
  logic [REG_W-1:0] base_q, idx_q;
  logic [NUM_W-1:0] num_q;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pds_seq #(.REG_W(REG_W), .NUM_W(NUM_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync),
    .start_i   (start_i),
    .op_pull_i (op_pull_i),
    .base_i    (base_reg_i),
    .count_i   (count_i),
    .sp_i      (sp_i),
    .refuse    (refuse),
    .trap_req  (trap_req),
    .cc_refuse (cc_refuse),
    .cc_finish (cc_finish),
    .sp_next   (sp_next),
    .step_done (step_done),
    .busy      (busy_o),
    .active    (active),
    .op_q      (op_q),
    .base_q    (base_q),
    .num_q     (num_q),
    .idx_q     (idx_q),
    .sp_q      (sp_q),
    .done_o    (done_o),
    .trap_o    (trap_o),
    .cc_o      (cc_q),
    .sp_o      (sp_o)
  );

  pds_limit #(.NUM_W(NUM_W)) limit_i (
    .op_pull   (op_q),
    .num       (num_q),
    .sp        (sp_q),
    .refuse    (refuse),
    .trap_req  (trap_req),
    .cc_refuse (cc_refuse),
    .cc_finish (cc_finish),
    .sp_next   (sp_next)
  );

  pds_route #(.DATA_W(DATA_W), .REG_W(REG_W), .NUM_W(NUM_W)) route_i (
    .clk        (clk),
    .rst_n      (rst_sync),
    .active     (active),
    .op_pull    (op_q),
    .base       (base_q),
    .num        (num_q),
    .idx        (idx_q),
    .top        (sp_q[TSA_LSB +: ADDR_W]),
    .rf_rd_data (rf_rd_data_i),
    .mem_rdata  (mem_rdata_i),
    .mem_ready  (mem_ready_i),
    .rf_rd_addr (rf_rd_addr_o),
    .rf_we      (rf_we_o),
    .rf_wr_addr (rf_wr_addr_o),
    .rf_wr_data (rf_wr_data_o),
    .mem_valid  (mem_valid_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o),
    .step_done  (step_done)
  );

  assign cc_o = cc_q;
endmodule

// File: tb/pds_engine_tb_top.sv
`timescale 1ns/1ps
module pds_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, op_pull_i;
  logic [3:0]  base_reg_i, count_i;
  logic [63:0] sp_i;
  logic        busy_o, done_o, trap_o;
  logic [3:0]  cc_o;
  logic [63:0] sp_o;
  logic [3:0]  rf_rd_addr_o, rf_wr_addr_o;
  logic [31:0] rf_rd_data_i, rf_wr_data_o;
  logic        rf_we_o, mem_valid_o, mem_ready_i, mem_we_o;
  logic [16:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  logic [31:0] rf [16];
  logic [31:0] exp_rf [16];
  logic [31:0] mem [int];
  logic [31:0] exp_mem [int];
  int checks = 0, failures = 0, beats = 0, seed_v;

  always #10 clk = ~clk;

  pds_engine dut_i (.*);

  assign rf_rd_data_i = rf[rf_rd_addr_o];

  always @(posedge clk) begin
    if (rf_we_o) rf[rf_wr_addr_o] <= rf_wr_data_o;
    if (mem_valid_o && mem_ready_i) begin
      beats++;
      if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
    end
  end

  function automatic logic [31:0] fill(int a);
    return 32'hC0DE_0000 ^ a;
  endfunction

  always @(negedge clk) begin
    mem_ready_i = ($urandom % 4) != 0;
    mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : fill(int'(mem_addr_o));
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] mk_sp(int top, bit ts, int sc, bit tw, int wc);
    logic [63:0] s;
    s = '0;
    s[63:49] = 15'h2B1D;
    s[48:32] = 17'(top);
    s[31]    = ts;
    s[30:16] = 15'(sc);
    s[15]    = tw;
    s[14:0]  = 15'(wc);
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    if (a < 16) return exp_rf[a];
    return exp_mem.exists(a) ? exp_mem[a] : fill(a);
  endfunction

  // reference model written from the requirements
  task automatic model(input bit pull, input logic [3:0] base, input logic [3:0] cnt,
                       input logic [63:0] sp, output logic [63:0] esp,
                       output logic [3:0] ecc, output bit etrap, output int ebeats);
    int n, top, sc, wc, avail, other, a, r;
    bit shrt, ovr;
    logic [31:0] v;
    n = (cnt == 0) ? 16 : int'(cnt);
    top = int'(sp[48:32]); sc = int'(sp[30:16]); wc = int'(sp[14:0]);
    avail = pull ? wc : sc;
    other = pull ? sc : wc;
    shrt = avail < n;
    ovr  = (other + n) > 32767;
    ebeats = 0;
    esp = sp;
    etrap = 0;
    if (shrt || ovr) begin
      ecc = {1'b1, ovr, shrt, 1'b0};
      etrap = (shrt && !sp[31]) || (ovr && !sp[15]);
      return;
    end
    for (int k = 0; k < n; k++) begin
      if (pull) begin
        a = (top - k) & 17'h1FFFF;
        r = (int'(base) + n - 1 - k) & 15;
        if (a >= 16) ebeats++;
        exp_rf[r] = exp_rd(a);
      end else begin
        a = (top + 1 + k) & 17'h1FFFF;
        r = (int'(base) + k) & 15;
        v = exp_rf[r];
        if (a < 16) exp_rf[a] = v;
        else begin exp_mem[a] = v; ebeats++; end
      end
    end
    top = pull ? top - n : top + n;
    sc  = pull ? sc + n : sc - n;
    wc  = pull ? wc - n : wc + n;
    esp[48:32] = 17'(top);
    esp[30:16] = 15'(sc);
    esp[14:0]  = 15'(wc);
    ecc = {3'b000, (pull ? wc : sc) == 0};
  endtask

  task automatic run_op(bit pull, logic [3:0] base, logic [3:0] cnt, logic [63:0] sp, string req);
    logic [63:0] esp;
    logic [3:0]  ecc;
    bit etrap, got;
    int ebeats, bad;
    for (int i = 0; i < 16; i++) exp_rf[i] = rf[i];
    exp_mem = mem;
    model(pull, base, cnt, sp, esp, ecc, etrap, ebeats);
    @(negedge clk);
    beats = 0;
    start_i = 1; op_pull_i = pull; base_reg_i = base; count_i = cnt; sp_i = sp;
    @(negedge clk);
    start_i = 0;
    got = 0;
    for (int w = 0; w < 3000 && !got; w++) begin
      @(negedge clk);
      if (done_o) got = 1;
    end
    chk(got, {req, " done seen"}, 64'(got), 64'd1);
    chk(sp_o == esp, {req, " R5 descriptor"}, sp_o, esp);
    chk(cc_o == ecc, {req, " R9 cond code"}, 64'(cc_o), 64'(ecc));
    chk(trap_o == etrap, {req, " R8 trap"}, 64'(trap_o), 64'(etrap));
    chk(beats == ebeats, {req, " R11 memory beats"}, 64'(beats), 64'(ebeats));
    bad = 0;
    for (int i = 0; i < 16; i++) if (rf[i] !== exp_rf[i]) bad++;
    chk(bad == 0, {req, " register file"}, 64'(bad), 64'd0);
    bad = (mem.num() != exp_mem.num()) ? 1 : 0;
    foreach (exp_mem[a]) if (!mem.exists(a) || mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, {req, " memory image"}, 64'(bad), 64'd0);
    @(negedge clk);
    chk(!done_o, {req, " R12 done single pulse"}, 64'(done_o), 64'd0);
  endtask

  initial begin
    #(20 * 190000);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd1357);
    rst_n = 0; start_i = 0; op_pull_i = 0; base_reg_i = 0; count_i = 0; sp_i = '0;
    for (int i = 0; i < 16; i++) rf[i] = $urandom;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy_o && !done_o && !trap_o && !mem_valid_o && !rf_we_o, "R12 reset outputs",
        {59'd0, busy_o, done_o, trap_o, mem_valid_o, rf_we_o}, 64'd0);
    chk(cc_o == 0 && sp_o == 0, "R12 reset results", sp_o, 64'd0);

    run_op(0, 4'd10, 4'd0, mk_sp(100, 0, 40, 0, 5), "R1 R2 R3 push16");
    run_op(1, 4'd10, 4'd0, mk_sp(116, 0, 24, 0, 21), "R1 R4 pull16");
    run_op(1, 4'd14, 4'd3, mk_sp(300, 0, 10, 0, 50), "R2 R4 pull wrap");
    run_op(0, 4'd3, 4'd5, mk_sp(2000, 1, 5, 1, 9), "R9 R3 push to empty space");
    run_op(1, 4'd0, 4'd4, mk_sp(2000, 0, 7, 0, 4), "R9 R4 pull to empty");
    run_op(0, 4'd1, 4'd4, mk_sp(500, 0, 3, 0, 9), "R6 R8 push short trap");
    run_op(0, 4'd1, 4'd4, mk_sp(500, 1, 3, 0, 9), "R6 R8 push short inhibited");
    run_op(0, 4'd2, 4'd3, mk_sp(600, 0, 90, 0, 32765), "R6 R8 push over trap");
    run_op(0, 4'd2, 4'd3, mk_sp(600, 0, 90, 1, 32765), "R6 R8 push over inhibited");
    run_op(0, 4'd2, 4'd3, mk_sp(600, 0, 90, 0, 32764), "R6 push over edge ok");
    run_op(0, 4'd7, 4'd8, mk_sp(700, 1, 2, 0, 32767), "R6 R8 push both one inhibited");
    run_op(1, 4'd5, 4'd3, mk_sp(800, 0, 20, 0, 2), "R7 R8 pull short trap");
    run_op(1, 4'd5, 4'd1, mk_sp(800, 0, 32767, 1, 9), "R7 R8 pull over inhibited");
    run_op(0, 4'd9, 4'd8, mk_sp(17'h1FFFC, 0, 100, 0, 0), "R10 push into registers");
    run_op(1, 4'd0, 4'd4, mk_sp(6, 0, 100, 0, 50), "R10 pull from registers");
    run_op(1, 4'd8, 4'd5, mk_sp(2, 0, 100, 0, 50), "R10 pull across zero");

    for (int t = 0; t < 60; t++) begin
      int top, sc, wc;
      top = ($urandom % 5 == 0) ? int'($urandom % 40) - 20 : int'($urandom % 131072);
      sc  = ($urandom % 3 == 0) ? int'($urandom % 20) : int'($urandom % 32768);
      wc  = ($urandom % 3 == 0) ? 32767 - int'($urandom % 20) : int'($urandom % 32768);
      run_op(bit'($urandom % 2), 4'($urandom), 4'($urandom),
             mk_sp(top & 17'h1FFFF, bit'($urandom), sc, bit'($urandom), wc), "R3 R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule